// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Triggered Update

The block turns a free-running clock into a stream of single-cycle clock-enable pulses. The pulses arrive at a programmable fraction of the input rate. The divisor is a fixed-point number with FRAC_W fractional bits. A field value v stands for the scaled divisor D = v + 2^FRAC_W, so a field of zero divides by exactly 1.0. A phase accumulator adds 2^FRAC_W on every advancing cycle. Each time the sum reaches D, it emits a pulse and keeps the remainder. Over a long run the average pulse rate is input_rate * 2^FRAC_W / D.

A second stage of the same kind may be placed in front of the main divider. Its pulses are the only cycles on which the main accumulator advances. Each stage has two divisor values. The staged value lives in a 32-bit configuration word and takes effect only when software writes that stage's trigger bit. The trigger bit then reads 1 until the new divisor has been moved into the active register. The move happens at the stage's next output pulse, so no period ever mixes two divisors. A gate input enables the whole block. While the gate is low, nothing advances, no pulse is produced, and triggers are discarded.

Top module: `frac_clk_div`

## Requirements
- R1: After reset, reg_rdata_o is 0 and both active divisor fields are 0. With gate_en_i high, clk_en_o and pre_en_o are then 1 on every cycle.
- R2: The main field is at bits [DIV_SHIFT +: DIV_W] and gives D = field + 2^FRAC_W. With the pre-divider at field 0 and FRAC_W = 0 for that stage, any window of k*D consecutive cycles holds exactly k*2^FRAC_W pulses on clk_en_o. This holds for every field value from 0 up to all ones.
- R3: A register write without a trigger bit updates only the staged value shown on reg_rdata_o. It does not change the output rate.
- R4: A write with bit TRIG_BIT = 1 while gate_en_i is high makes that bit read 1 from the next cycle on. The bit returns to 0 once the staged main field is active. Throughout, every non-trigger bit reads back exactly as written.
- R5: The active main divisor changes, and the main trigger bit falls, only directly after a cycle in which clk_en_o was 1 (or the gate was low).
- R6: A trigger written while gate_en_i is low is dropped. The trigger bit reads 0 on the next cycle and the active divisor stays as it was.
- R7: While gate_en_i is low, clk_en_o and pre_en_o stay 0 and both accumulators hold their state.
- R8: The pre-divider field is at bits [PRE_SHIFT +: PRE_W] and gives Dp = field + 2^PRE_FRAC_W. It is committed by its own trigger bit PRE_TRIG_BIT at a pre_en_o pulse. clk_en_o can be 1 only in a cycle where pre_en_o is 1. Any window of k*D*Dp cycles holds exactly k*2^FRAC_W*2^PRE_FRAC_W pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_en_i | input | 1 | Block enable; while low nothing advances and triggers are dropped |
| reg_we_i | input | 1 | Write strobe for the configuration word |
| reg_wdata_i | input | 32 | Configuration word written on reg_we_i |
| reg_rdata_o | output | 32 | Stored word, with the trigger bits showing pending updates |
| pre_en_o | output | 1 | Pulse stream of the pre-divider stage |
| clk_en_o | output | 1 | Divided clock-enable pulse stream |

## Verification
The assertions check on every cycle that a trigger only retires at its stage's output pulse or under gate-off. They also check that the gate suppresses both pulse streams and clears pending triggers, and that main pulses never occur outside pre-divider pulses. The exact long-run pulse count for each divisor, the isolation of the staged field from the active one, the readback of untouched bits, and the dropping of gated triggers can only be shown by the bench's sweeps. The bench counts pulses over windows that are exact multiples of the divisors.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int REG_W = 32;
  typedef logic [REG_W-1:0] fcd_word_t;

  function automatic int acc_width(input int w, input int f);
    return ((w > f) ? w : f) + 2;
  endfunction
endpackage

// File: rtl/fcd_trig.sv
module fcd_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic trig_i,
  input  logic bound_i,
  output logic busy_o,
  output logic commit_o
);
  logic busy_q, busy_d;

  assign commit_o = busy_q & bound_i & gate_i;

  always_comb begin
    busy_d = busy_q;
    if (!gate_i)       busy_d = 1'b0;
    else if (commit_o) busy_d = 1'b0;
    else if (trig_i)   busy_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_d;

  assign busy_o = busy_q;
endmodule

// File: rtl/fcd_stage.sv
module fcd_stage #(
  parameter int W = 4,
  parameter int F = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gate_i,
  input  logic         adv_i,
  input  logic [W-1:0] staged_i,
  input  logic         trig_i,
  output logic         pulse_o,
  output logic         busy_o
);
  localparam int ACC_W = fcd_pkg::acc_width(W, F);
  localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << F;

  logic [W-1:0]     act_q;
  logic [ACC_W-1:0] acc_q, sum, sdiv;
  logic             commit;

  assign sdiv    = ACC_W'(act_q) + STEP;
  assign sum     = acc_q + STEP;
  assign pulse_o = gate_i & adv_i & (sum >= sdiv);

  fcd_trig u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .gate_i  (gate_i),
    .trig_i  (trig_i),
    .bound_i (pulse_o),
    .busy_o  (busy_o),
    .commit_o(commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      acc_q <= '0;
      act_q <= '0;
    end else begin
      if (gate_i && adv_i) acc_q <= pulse_o ? (sum - sdiv) : sum;
      if (commit) act_q <= staged_i;
    end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int DIV_W        = 8,
  parameter int FRAC_W       = 4,
  parameter int DIV_SHIFT    = 0,
  parameter int PRE_W        = 4,
  parameter int PRE_FRAC_W   = 0,
  parameter int PRE_SHIFT    = 16,
  parameter int TRIG_BIT     = 31,
  parameter int PRE_TRIG_BIT = 30
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        gate_en_i,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        pre_en_o,
  output logic        clk_en_o
);
  import fcd_pkg::*;

  localparam fcd_word_t TRIG_MASK = (fcd_word_t'(1) << TRIG_BIT) |
                                    ((PRE_W > 0) ? (fcd_word_t'(1) << PRE_TRIG_BIT) : '0);

  fcd_word_t cfg_q;
  logic      main_busy, pre_busy, pre_pulse;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       cfg_q <= '0;
    else if (reg_we_i) cfg_q <= reg_wdata_i & ~TRIG_MASK;

  generate
    if (PRE_W > 0) begin : g_pre
      fcd_stage #(.W(PRE_W), .F(PRE_FRAC_W)) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .gate_i  (gate_en_i),
        .adv_i   (1'b1),
        .staged_i(cfg_q[PRE_SHIFT +: PRE_W]),
        .trig_i  (reg_we_i & reg_wdata_i[PRE_TRIG_BIT]),
        .pulse_o (pre_pulse),
        .busy_o  (pre_busy)
      );
    end else begin : g_nopre
      assign pre_pulse = gate_en_i;
      assign pre_busy  = 1'b0;
    end
  endgenerate

  fcd_stage #(.W(DIV_W), .F(FRAC_W)) u_main (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .gate_i  (gate_en_i),
    .adv_i   (pre_pulse),
    .staged_i(cfg_q[DIV_SHIFT +: DIV_W]),
    .trig_i  (reg_we_i & reg_wdata_i[TRIG_BIT]),
    .pulse_o (clk_en_o),
    .busy_o  (main_busy)
  );

  always_comb begin
    reg_rdata_o = cfg_q;
    reg_rdata_o[TRIG_BIT] = main_busy;
    if (PRE_W > 0) reg_rdata_o[PRE_TRIG_BIT] = pre_busy;
  end

  assign pre_en_o = pre_pulse;
endmodule

// File: rtl/fcd_chk.sv
module fcd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic gate_en_i,
  input logic pre_en_o,
  input logic clk_en_o,
  input logic main_busy_i,
  input logic pre_busy_i
);
  assert_gate_silences_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_en_i |-> (!clk_en_o && !pre_en_o));

  assert_gated_trig_dropped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_en_i |=> (!main_busy_i && !pre_busy_i));

  assert_commit_on_boundary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(main_busy_i) |-> $past(clk_en_o || !gate_en_i));

  assert_pre_commit_on_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pre_busy_i) |-> $past(pre_en_o || !gate_en_i));

  assert_main_follows_pre_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> pre_en_o);
endmodule

bind frac_clk_div fcd_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gate_en_i  (gate_en_i),
  .pre_en_o   (pre_en_o),
  .clk_en_o   (clk_en_o),
  .main_busy_i(main_busy),
  .pre_busy_i (pre_busy)
);

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;
  localparam int DW = 4, FW = 2, DS = 4, PW = 2, PFW = 0, PS = 12, TB = 31, PTB = 30;
  localparam int S = 1 << FW;
  localparam logic [31:0] SPARE = 32'h05A0_000C;

  logic clk = 1'b0, rst_n = 1'b0, gate = 1'b0, we = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic pre_en, clk_en;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  frac_clk_div #(.DIV_W(DW), .FRAC_W(FW), .DIV_SHIFT(DS), .PRE_W(PW), .PRE_FRAC_W(PFW),
                 .PRE_SHIFT(PS), .TRIG_BIT(TB), .PRE_TRIG_BIT(PTB)) u_frac_clk_div (
    .clk_i(clk), .rst_ni(rst_n), .gate_en_i(gate), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pre_en_o(pre_en), .clk_en_o(clk_en));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input int v, input int p, input bit t, input bit pt);
    logic [31:0] w = SPARE;
    w[DS +: DW] = v[DW-1:0];
    w[PS +: PW] = p[PW-1:0];
    w[TB] = t;
    w[PTB] = pt;
    return w;
  endfunction

  task automatic wr(input logic [31:0] d);
    wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic count(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (clk_en) c++;
      @(negedge clk);
    end
  endtask

  // write with trigger and wait for its retirement
  task automatic commit(input int v, input int p, input bit main);
    logic prev;
    int bit_i;
    bit_i = main ? TB : PTB;
    wr(word(v, p, main, !main));
    chk("R4 busy set", rdata[bit_i], 1);
    prev = 1'b0;
    for (int i = 0; i < 200 && rdata[bit_i]; i++) begin
      prev = main ? clk_en : pre_en;
      @(negedge clk);
    end
    chk("R4 busy cleared", rdata[bit_i], 0);
    chk(main ? "R5 commit at pulse" : "R8 pre commit at pulse", prev, 1);
    chk("R4 other bits kept", rdata, word(v, p, 0, 0));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int c, cur;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata reset", rdata, 0);
    gate = 1'b1;
    @(negedge clk);
    count(10, c);
    chk("R1 divide by one", c, 10);

    // R2 sweep of every main field value, pre at 1
    for (int v = 0; v < (1 << DW); v++) begin
      commit(v, 0, 1);
      count(2 * (v + S), c);
      chk("R2 pulse count", c, 2 * S);
    end
    cur = (1 << DW) - 1;

    // R3 staged write without trigger keeps rate
    wr(word(3, 0, 0, 0));
    chk("R3 staged readback", rdata, word(3, 0, 0, 0));
    count(3 * (cur + S), c);
    chk("R3 rate unchanged", c, 3 * S);

    // R6/R7 gate off
    gate = 1'b0;
    @(negedge clk);
    wr(word(9, 0, 1, 0));
    chk("R6 gated trigger reads 0", rdata[TB], 0);
    count(20, c);
    chk("R7 no pulses while gated", c, 0);
    chk("R7 no pre pulses while gated", pre_en, 0);
    gate = 1'b1;
    @(negedge clk);
    count(2 * (cur + S), c);
    chk("R6 active divisor kept", c, 2 * S);

    // R8 pre-divider sweep
    for (int p = 0; p < (1 << PW); p++) begin
      for (int k = 0; k < 3; k++) begin
        int v;
        v = (k == 0) ? 0 : ((k == 1) ? 7 : 15);
        commit(v, p, 1);
        commit(v, p, 0);
        count(2 * (v + S) * (p + 1), c);
        chk("R8 chained pulse count", c, 2 * S);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule